// File: doc/BRIEF.md
# Reset Boot PROM Overlay

After a machine reset this block places a 32-byte bootstrap PROM over the bottom of the address space. The processor's first instruction fetch at address zero is therefore served by the PROM. The bus interface is simple: an address, read and write strobes, read data returned to the processor, and read data coming from the RAM. While the overlay is armed, reads inside the 32-byte window come from the PROM. Writes to the same addresses always go to the RAM underneath. This lets the loader in the PROM copy a disk sector into RAM at the very addresses it is running from.

Any read or write to the first address above the window disarms the overlay. From the next cycle on, the whole address space, including the window, is plain RAM. The disarm is held until the next reset. The PROM image is generated when the design is elaborated, from the disk controller's port base, the read-sector command and the address of the next loader stage. The default image is a sector-read loop. It requests sector 1 with command 0x8C, stores incoming bytes upward from 0x0000, then checks status and either jumps on to 0x007D or halts.

Top module: `boot_overlay`

## Requirements
- R1: Once reset is released, the overlay is armed. A read (`cpu_rd`=1, `cpu_wr`=0) at any address from 0x0000 to 0x001F raises `rom_sel`, holds `ram_re` low and returns the PROM byte at that offset on `cpu_rdata`.
- R2: With the default parameters, the PROM holds these bytes among others: offset 0x00 = 0xDB, 0x01 = 0xEC, 0x03 = 0x6F, 0x08 = 0x3E, 0x09 = 0x8C, 0x0B = 0xE8, 0x1D = 0x7D, 0x1F = 0x76.
- R3: A write (`cpu_wr`=1) anywhere, including inside the window while the overlay is armed, raises `ram_we` and never raises `rom_sel`.
- R4: A read at an address of 0x0020 or above always raises `ram_re`, keeps `rom_sel` low and returns `ram_rdata` on `cpu_rdata`, whether the overlay is armed or not.
- R5: A read or a write at address 0x0020 disarms the overlay at the next rising clock edge. The access at 0x0020 itself is served by RAM. Afterwards, reads at 0x0000 to 0x001F return `ram_rdata` with `rom_sel` low.
- R6: Once disarmed, the overlay stays disarmed through any further reads or writes at any address.
- R7: Asserting `rst_n` low re-arms the overlay. After release, a read at 0x0000 again returns the PROM byte.
- R8: Accesses to any address other than 0x0020 leave the overlay armed. This includes 0x001F, 0x0021 and 0x1020, which shares its low bits with 0x0020.
- R9: With no strobe active, `rom_sel`, `ram_re` and `ram_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low machine reset; arms the overlay |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| ram_rdata | input | 8 | Read data from the RAM array |
| cpu_rdata | output | 8 | Read data returned to the processor (PROM or RAM) |
| rom_sel | output | 1 | High while the PROM serves the current read |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable, a pass-through of the write strobe |

## Verification
While the overlay is armed, the bench reads several PROM offsets and places a distinct RAM value under each read. This shows that a returned byte came from the PROM and not from the RAM. Writes into the window show that the RAM write path stays open while the PROM answers reads at the same addresses. Reads at 0x0021, 0x001F and the alias 0x1020 confirm that only the exact disarm address is decoded. Separate tests disarm with a read and with a write, then re-arm with a mid-run reset. Together they separate a read-only disarm, a non-sticky latch and a reset that fails to restore the PROM.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

  // Byte at offset idx of the sector-read loader image.
  // base : controller command/status port, +2 sector, +3 data, +4 wait
  function automatic logic [7:0] loader_byte(input int unsigned idx,
                                             input logic [7:0]  base,
                                             input logic [7:0]  cmd,
                                             input logic [15:0] exit_addr);
    logic [7:0] b;
    case (idx)
      0:  b = 8'hDB;            // input from wait port
      1:  b = base + 8'd4;
      2:  b = 8'hAF;            // clear accumulator
      3:  b = 8'h6F;            // pointer low = 0
      4:  b = 8'h67;            // pointer high = 0
      5:  b = 8'h3C;            // accumulator = 1 (sector)
      6:  b = 8'hD3;            // output sector number
      7:  b = base + 8'd2;
      8:  b = 8'h3E;            // load command
      9:  b = cmd;
      10: b = 8'hD3;            // output command
      11: b = base;
      12: b = 8'hDB;            // loop: wait for request
      13: b = base + 8'd4;
      14: b = 8'hB7;            // test flags
      15: b = 8'hF2;            // jump if done
      16: b = 8'h19;
      17: b = 8'h00;
      18: b = 8'hDB;            // input data byte
      19: b = base + 8'd3;
      20: b = 8'h77;            // store at pointer
      21: b = 8'h23;            // advance pointer
      22: b = 8'hC3;            // back to loop
      23: b = 8'h0C;
      24: b = 8'h00;
      25: b = 8'hDB;            // read status
      26: b = base;
      27: b = 8'hB7;
      28: b = 8'hCA;            // jump to next stage when clean
      29: b = exit_addr[7:0];
      30: b = exit_addr[15:8];
      31: b = 8'h76;            // halt on error
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // True when addr falls inside a window of 2**aw bytes at zero.
  function automatic logic in_window(input logic [15:0] addr, input int unsigned aw);
    return (addr >> aw) == 16'h0000;
  endfunction

endpackage

// File: rtl/boot_prom.sv
module boot_prom #(
  parameter int unsigned   PROM_AW   = 5,
  parameter logic [7:0]    CTL_BASE  = 8'hE8,
  parameter logic [7:0]    RD_CMD    = 8'h8C,
  parameter logic [15:0]   EXIT_ADDR = 16'h007D
) (
  input  logic [PROM_AW-1:0] idx,
  output logic [7:0]         data
);
  localparam int unsigned PROM_BYTES = 1 << PROM_AW;

  function automatic logic [8*PROM_BYTES-1:0] build_image();
    logic [8*PROM_BYTES-1:0] img;
    img = '0;
    for (int i = 0; i < PROM_BYTES; i++)
      img[8*i +: 8] = boot_overlay_pkg::loader_byte(i, CTL_BASE, RD_CMD, EXIT_ADDR);
    return img;
  endfunction

  localparam logic [8*PROM_BYTES-1:0] IMAGE = build_image();

  assign data = IMAGE[8*idx +: 8];
endmodule

// File: rtl/overlay_ctrl.sv
module overlay_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PROM_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              armed,
  output logic              disarm_evt
);
  localparam logic [ADDR_W-1:0] DISARM_ADDR = ADDR_W'(1 << PROM_AW);

  logic armed_q;

  assign disarm_evt = (rd | wr) && (addr == DISARM_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b1;
    else if (disarm_evt) armed_q <= 1'b0;
  end

  assign armed = armed_q;
endmodule

// File: rtl/bus_steer.sv
module bus_steer #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PROM_AW = 5
) (
  input  logic              armed,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        prom_data,
  input  logic [7:0]        ram_rdata,
  output logic              win_hit,
  output logic              rom_sel,
  output logic              ram_re,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata
);
  assign win_hit   = addr[ADDR_W-1:PROM_AW] == '0;
  assign rom_sel   = armed & rd & ~wr & win_hit;
  assign ram_re    = rd & ~rom_sel;
  assign ram_we    = wr;
  assign cpu_rdata = rom_sel ? prom_data : ram_rdata;
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PROM_AW   = 5,
  parameter logic [7:0]  CTL_BASE  = 8'hE8,
  parameter logic [7:0]  RD_CMD    = 8'h8C,
  parameter logic [15:0] EXIT_ADDR = 16'h007D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        cpu_rdata,
  output logic              rom_sel,
  output logic              ram_re,
  output logic              ram_we
);
  logic       armed_w;
  logic       disarm_w;
  logic       win_w;
  logic [7:0] prom_w;

  overlay_ctrl #(.ADDR_W(ADDR_W), .PROM_AW(PROM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .armed(armed_w), .disarm_evt(disarm_w)
  );

  boot_prom #(.PROM_AW(PROM_AW), .CTL_BASE(CTL_BASE), .RD_CMD(RD_CMD),
              .EXIT_ADDR(EXIT_ADDR)) u_prom (
    .idx(cpu_addr[PROM_AW-1:0]), .data(prom_w)
  );

  bus_steer #(.ADDR_W(ADDR_W), .PROM_AW(PROM_AW)) u_steer (
    .armed(armed_w), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .prom_data(prom_w), .ram_rdata(ram_rdata), .win_hit(win_w),
    .rom_sel(rom_sel), .ram_re(ram_re), .ram_we(ram_we), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PROM_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        ram_rdata,
  input logic [7:0]        cpu_rdata,
  input logic              rom_sel,
  input logic              ram_re,
  input logic              ram_we,
  input logic              armed,
  input logic              disarm_evt
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(1 << PROM_AW);

  logic low_addr;
  logic hit_disarm;
  assign low_addr   = cpu_addr < LIMIT;
  assign hit_disarm = (cpu_rd | cpu_wr) && cpu_addr == LIMIT;

  AST_ARMED_READ_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cpu_rd && !cpu_wr && low_addr |-> rom_sel && !ram_re); // R1
  AST_WRITE_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> ram_we && !rom_sel); // R3
  AST_HIGH_READ_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !low_addr |-> ram_re && !rom_sel && cpu_rdata == ram_rdata); // R4
  AST_DISARM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_disarm |=> !armed); // R5
  AST_DISARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !armed); // R6
  AST_DISARMED_READ_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && cpu_rd |-> !rom_sel && cpu_rdata == ram_rdata); // R6
  AST_KEEP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !disarm_evt |=> armed); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd && !cpu_wr |-> !rom_sel && !ram_re && !ram_we); // R9
endmodule

bind boot_overlay boot_overlay_chk #(.ADDR_W(ADDR_W), .PROM_AW(PROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .rom_sel(rom_sel),
  .ram_re(ram_re), .ram_we(ram_we), .armed(armed_w), .disarm_evt(disarm_w)
);

// File: tb/test_boot_overlay.sv
module test_boot_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  ram_rdata = '0;
  logic [7:0]  cpu_rdata;
  logic        rom_sel, ram_re, ram_we;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay i_boot_overlay (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .rom_sel(rom_sel),
    .ram_re(ram_re), .ram_we(ram_we)
  );

  // {op[1:0] (1 read, 2 write), addr[15:0], ram[7:0], exp_data[7:0], exp_sel, exp_we, tag[3:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd1, 16'h0000, 8'h11, 8'hDB, 1'b1, 1'b0, 4'd2},  // R1 R2
    {2'd1, 16'h0001, 8'h12, 8'hEC, 1'b1, 1'b0, 4'd2},
    {2'd1, 16'h0003, 8'h13, 8'h6F, 1'b1, 1'b0, 4'd2},
    {2'd1, 16'h0009, 8'h14, 8'h8C, 1'b1, 1'b0, 4'd2},
    {2'd1, 16'h001D, 8'h15, 8'h7D, 1'b1, 1'b0, 4'd2},
    {2'd1, 16'h001F, 8'h16, 8'h76, 1'b1, 1'b0, 4'd8},  // R8 edge of window
    {2'd2, 16'h0005, 8'h17, 8'h17, 1'b0, 1'b1, 4'd3},  // R3 write in window
    {2'd1, 16'h0040, 8'h5A, 8'h5A, 1'b0, 1'b0, 4'd4},  // R4
    {2'd1, 16'h0021, 8'h22, 8'h22, 1'b0, 1'b0, 4'd8},  // R8
    {2'd1, 16'h1020, 8'h33, 8'h33, 1'b0, 1'b0, 4'd8},  // R8 alias
    {2'd1, 16'h0008, 8'h34, 8'h3E, 1'b1, 1'b0, 4'd8},  // still armed
    {2'd1, 16'h0020, 8'h44, 8'h44, 1'b0, 1'b0, 4'd5},  // R5 disarm by read
    {2'd1, 16'h0000, 8'h66, 8'h66, 1'b0, 1'b0, 4'd5},
    {2'd1, 16'h001F, 8'h77, 8'h77, 1'b0, 1'b0, 4'd6},  // R6
    {2'd2, 16'h0002, 8'h78, 8'h78, 1'b0, 1'b1, 4'd6},
    {2'd1, 16'h000B, 8'h88, 8'h88, 1'b0, 1'b0, 4'd6}
  };

  task automatic check(input string req, input logic [7:0] d, input logic s,
                       input logic w, input logic [7:0] ed, input logic es, input logic ew);
    n_checks++;
    if (d !== ed || s !== es || w !== ew) begin
      n_fail++;
      $display("FAIL %s: data=%h sel=%b we=%b expected data=%h sel=%b we=%b",
               req, d, s, w, ed, es, ew);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [7:0] r);
    @(negedge clk);
    cpu_rd = (op == 2'd1);
    cpu_wr = (op == 2'd2);
    cpu_addr = a;
    ram_rdata = r;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    #2;
    // R9: idle bus after reset
    check("R9 idle", cpu_rdata, rom_sel, ram_we, ram_rdata, 1'b0, 1'b0);
    n_checks++;
    if (ram_re !== 1'b0) begin n_fail++; $display("FAIL R9: ram_re=%b expected 0", ram_re); end

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][39:38], VEC[i][37:22], VEC[i][21:14]);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), cpu_rdata, rom_sel, ram_we,
            VEC[i][13:6], VEC[i][5], VEC[i][4]);
    end

    // R7: reset re-arms
    do_reset();
    drive(2'd1, 16'h0000, 8'h99);
    check("R7 rearm", cpu_rdata, rom_sel, ram_we, 8'hDB, 1'b1, 1'b0);
    drive(2'd1, 16'h000B, 8'h9A);
    check("R2 port byte", cpu_rdata, rom_sel, ram_we, 8'hE8, 1'b1, 1'b0);

    // R5: disarm by write
    drive(2'd2, 16'h0020, 8'h00);
    check("R5 write 0x20", cpu_rdata, rom_sel, ram_we, 8'h00, 1'b0, 1'b1);
    drive(2'd1, 16'h0000, 8'hC3);
    check("R5 after write disarm", cpu_rdata, rom_sel, ram_we, 8'hC3, 1'b0, 1'b0);
    n_checks++;
    if (ram_re !== 1'b1) begin n_fail++; $display("FAIL R5: ram_re=%b expected 1", ram_re); end

    // R6: repeated disarm-address access does not rearm
    drive(2'd1, 16'h0020, 8'h01);
    drive(2'd1, 16'h0001, 8'hA5);
    check("R6 stays off", cpu_rdata, rom_sel, ram_we, 8'hA5, 1'b0, 1'b0);

    drive(2'd0, 16'h0000, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule